// File: doc/BRIEF.md
# Angle-Domain Carrier Phase Averager

This block estimates the carrier phase of a QPSK sample stream using only angle arithmetic. Each incoming sample arrives as a full-turn angle code. Its two most significant bits carry the data quadrant, and the block discards them, so the working angle lives on a circle whose period is a quarter turn (2^W codes). The reduced angles then pass through a pipelined tree of pairwise midpoint cells. Each cell returns the point halfway along the shorter arc between its two operands. It never takes an arithmetic mean, so the estimate does not jump when a cluster of angles straddles the wrap point.

The tree runs on a stream and accepts one sample per accepted beat. Level 1 pairs each sample with the one before it. Level l pairs the current level-(l-1) result with the level-(l-1) result from 2^(l-1) samples earlier. One result from each cell is therefore shared by several overlapping windows, and every window of WIN consecutive samples yields an estimate at the cost of one cell per level. Both edges use valid/ready handshakes. When the output is held (out_valid high, out_ready low), the whole pipeline freezes and in_ready drops in the same cycle. When the output is not held, in_ready is high.

Top module: `bary_phase_avg`

## Requirements
- R1: During and right after reset, out_valid is 0 and in_ready is 1.
- R2: Only the low W bits of in_angle affect the result. The upper two bits (the quadrant, where one full turn is 2^(W+2) codes) are ignored.
- R3: A cell with an older operand a and a newer operand b treats d = (b − a) mod 2^W as a two's-complement W-bit value and returns (a + floor(d/2)) mod 2^W. For example, a=254 and b=2 give 0 when W=8.
- R4: When d equals exactly 2^(W-1), the cell moves in the positive direction and returns (a + 2^(W-2)) mod 2^W.
- R5: With LOG = log2(WIN) levels, the result for sample n is L_LOG(n). Here L_0(n) is the reduced sample n, and L_l(n) is the cell applied to older operand L_(l-1)(n − 2^(l-1)) and newer operand L_(l-1)(n).
- R6: No result is presented until WIN samples have been accepted. After that, each accepted sample yields exactly one result, and results come out in acceptance order.
- R7: While out_ready stays high, the result for a sample accepted on rising edge k becomes visible after rising edge k+LOG−1. For the defaults, this is two edges after acceptance.
- R8: While out_valid is high and out_ready is low, in_ready is 0 and out_valid and out_phase hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input angle is valid |
| in_ready | output | 1 | Block accepts an input this cycle |
| in_angle | input | W+2 | Full-turn angle code; the upper 2 bits are the quadrant |
| out_valid | output | 1 | Phase estimate is valid |
| out_ready | input | 1 | Downstream accepts the estimate |
| out_phase | output | W | Averaged phase, modulo a quarter turn |

## Verification
The bench feeds four kinds of input. A run of pairs straddling the wrap point (254 and 2) must average to exactly 0; a plain mean would give about half the period. Inputs alternating by exactly half a period must yield the alternating 64/192 pattern, which only the positive tie rule produces. A constant low code carrying random quadrant bits must come back unchanged, which separates stripping from leakage of the upper bits. Long random streams with random valid and ready gaps are compared against a per-level model of the overlapping tree, and this exposes wrong delays, wrong operand order or rounding, lost or duplicated results under back-pressure, and results released before the window is full.

// File: rtl/bary_pkg.sv
package bary_pkg;
  // Side information that travels with each angle through the tree.
  typedef struct packed {
    logic vld;   // stage holds a sample
    logic full;  // sample completes a whole window
  } bary_tag_t;
endpackage

// File: rtl/bary_cell.sv
// Midpoint of two angles along the shorter arc of a 2^W circle.
module bary_cell #(
  parameter int W = 8
) (
  input  logic [W-1:0] older,
  input  logic [W-1:0] newer,
  output logic [W-1:0] mid
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QTR  = HALF >> 1;

  logic [W-1:0]        diff;
  logic signed [W-1:0] sdiff;
  logic [W-1:0]        step;

  always_comb begin
    diff  = newer - older;
    sdiff = $signed(diff);
    if (diff == HALF) step = QTR;          // exact tie: go the positive way
    else              step = $unsigned(sdiff >>> 1);
    mid = older + step;
  end
endmodule

// File: rtl/bary_level.sv
// One tree level: pairs the current value with the one DLY samples earlier.
module bary_level
  import bary_pkg::*;
#(
  parameter int W   = 8,
  parameter int DLY = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  bary_tag_t tag_i,
  input  logic [W-1:0] ang_i,
  output bary_tag_t tag_o,
  output logic [W-1:0] ang_o
);
  logic [W-1:0] hist [DLY];
  logic [W-1:0] mid;

  bary_cell #(.W(W)) u_cell (
    .older (hist[DLY-1]),
    .newer (ang_i),
    .mid   (mid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_o <= '0;
      ang_o <= '0;
      for (int i = 0; i < DLY; i++) hist[i] <= '0;
    end else if (adv) begin
      tag_o <= tag_i;
      if (tag_i.vld) begin
        ang_o   <= mid;
        hist[0] <= ang_i;
        for (int i = 1; i < DLY; i++) hist[i] <= hist[i-1];
      end
    end
  end
endmodule

// File: rtl/bary_phase_avg.sv
module bary_phase_avg
  import bary_pkg::*;
#(
  parameter int W   = 8,
  parameter int WIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W+1:0]   in_angle,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_phase
);
  localparam int AW  = W + 2;
  localparam int LOG = $clog2(WIN);
  localparam logic [AW-1:0]  MASK = (AW'(1) << W) - AW'(1);
  localparam logic [LOG-1:0] LAST = LOG'(WIN - 1);

  bary_tag_t    tag_s [LOG+1];
  logic [W-1:0] ang_s [LOG+1];
  logic [LOG-1:0] fill;
  logic adv;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  // Count accepted samples until one full window has been seen.
  always_ff @(posedge clk) begin
    if (!rst_n)                                   fill <= '0;
    else if (in_valid && adv && fill != LAST)     fill <= fill + LOG'(1);
  end

  // Quadrant strip: keep the angle modulo a quarter turn.
  always_comb begin
    tag_s[0].vld  = in_valid;
    tag_s[0].full = (fill == LAST);
    ang_s[0]      = W'(in_angle & MASK);
  end

  for (genvar l = 1; l <= LOG; l++) begin : g_lvl
    bary_level #(.W(W), .DLY(1 << (l - 1))) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .tag_i (tag_s[l-1]),
      .ang_i (ang_s[l-1]),
      .tag_o (tag_s[l]),
      .ang_o (ang_s[l])
    );
  end

  assign out_valid = tag_s[LOG].vld && tag_s[LOG].full;
  assign out_phase = ang_s[LOG];
endmodule

// File: rtl/bary_phase_avg_chk.sv
module bary_phase_avg_chk #(
  parameter int W   = 8,
  parameter int WIN = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_phase
);
  logic [31:0] acc_n, out_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_n <= '0;
      out_n <= '0;
    end else begin
      if (in_valid && in_ready)   acc_n <= acc_n + 32'd1;
      if (out_valid && out_ready) out_n <= out_n + 32'd1;
    end
  end

  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phase)));

  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_n >= 32'(WIN)));

  a_r6_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_n + 32'(WIN) - 32'd1 < acc_n));
endmodule

bind bary_phase_avg bary_phase_avg_chk #(.W(W), .WIN(WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_phase (out_phase)
);

// File: tb/tb_bary_phase_avg.sv
`timescale 1ns/1ps
module tb_bary_phase_avg;
  localparam int W = 8;
  localparam int WIN = 8;
  localparam int LOG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W+1:0] in_angle = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_phase;

  always #2 clk = ~clk;

  bary_phase_avg #(.W(W), .WIN(WIN)) dut (.*);

  int checks = 0, fails = 0;
  int acc = 0, outs = 0, cyc = 0;
  int mode = 0;            // 0 model only, 1 constant, 2 tie alternation
  logic [W-1:0] cval = '0;
  logic [W-1:0] hq [0:LOG][$];
  logic [W-1:0] exp_q [$];
  logic held = 1'b0;
  logic [W-1:0] held_ph = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Cell behaviour as stated in R3/R4.
  function automatic logic [W-1:0] arc_mid(input logic [W-1:0] o, input logic [W-1:0] n);
    logic [W-1:0] d;
    logic signed [W-1:0] sd;
    d = n - o;
    if (d == 8'h80) return o + 8'h40;
    sd = $signed(d);
    sd = sd >>> 1;
    return o + $unsigned(sd);
  endfunction

  task automatic model_push(input logic [W-1:0] s);
    int n;
    n = hq[0].size();
    hq[0].push_back(s);
    for (int l = 1; l <= LOG; l++) begin
      int d;
      d = 1 << (l - 1);
      if (n >= d) hq[l].push_back(arc_mid(hq[l-1][n-d], hq[l-1][n]));
      else        hq[l].push_back(arc_mid('0, hq[l-1][n]));
    end
    if (n >= WIN - 1) exp_q.push_back(hq[LOG][n]);
  endtask

  task automatic drive(input bit iv, input logic [W+1:0] ang, input bit ordy);
    @(negedge clk);
    in_valid = iv;
    in_angle = ang;
    out_ready = ordy;
    #1;
    if (held) begin
      chk(out_valid === 1'b1, "R8 valid held", int'(out_valid), 1);
      chk(out_phase === held_ph, "R8 phase held", int'(out_phase), int'(held_ph));
    end
    held = 1'b0;
    if (out_valid && !out_ready) begin
      chk(in_ready === 1'b0, "R8 in_ready low", int'(in_ready), 0);
      held = 1'b1;
      held_ph = out_phase;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected result", int'(out_phase), -1);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(out_phase === e, "R5 tree result", int'(out_phase), int'(e));
        if (mode == 1)
          chk(out_phase === cval, "R2/R3 constant result", int'(out_phase), int'(cval));
        if (mode == 2) begin
          logic [W-1:0] t;
          t = ((outs + WIN - 1) % 2 == 1) ? 8'd64 : 8'd192;
          chk(out_phase === t, "R4 tie direction", int'(out_phase), int'(t));
        end
      end
      outs++;
    end
    if (in_valid && in_ready) begin
      acc++;
      model_push(in_angle[W-1:0]);
    end
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int l = 0; l <= LOG; l++) hq[l].delete();
    exp_q.delete();
    acc = 0; outs = 0; cyc = 0; held = 1'b0; mode = 0;
  endtask

  task automatic drain_and_count(input string tag);
    repeat (12) drive(1'b0, '0, 1'b1);
    chk(outs == acc - (WIN - 1), {"R6 result count ", tag}, outs, acc - (WIN - 1));
  endtask

  task automatic body();
    void'($urandom(32'd20240611));
    // Reset state and latency
    do_reset();
    #1;
    chk(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    for (int i = 0; i < WIN; i++) begin
      drive(1'b1, 10'($urandom), 1'b1);
      chk(out_valid === 1'b0, "R6 no early result", int'(out_valid), 0);
    end
    drive(1'b0, '0, 1'b1);
    chk(out_valid === 1'b0, "R7 not yet at cycle 8", int'(out_valid), 0);
    drive(1'b0, '0, 1'b1);
    chk(out_valid === 1'b0, "R7 not yet at cycle 9", int'(out_valid), 0);
    drive(1'b0, '0, 1'b1);
    chk(out_valid === 1'b1, "R7 result at cycle 10", int'(out_valid), 1);
    drain_and_count("latency");

    // Wrap point: 254 and 2 average to 0 (R3)
    do_reset();
    mode = 1; cval = 8'd0;
    for (int i = 0; i < 24; i++)
      drive(1'b1, {2'($urandom), (i % 2 == 0) ? 8'd254 : 8'd2}, 1'b1);
    drain_and_count("wrap");

    // Exact half-period ties (R4)
    do_reset();
    mode = 2;
    for (int i = 0; i < 24; i++)
      drive(1'b1, {2'($urandom), (i % 2 == 0) ? 8'd0 : 8'd128}, 1'b1);
    drain_and_count("tie");

    // Quadrant bits ignored (R2)
    do_reset();
    mode = 1; cval = 8'd77;
    for (int i = 0; i < 24; i++)
      drive(1'b1, {2'($urandom), 8'd77}, ($urandom % 4) != 0);
    drain_and_count("quadrant");

    // Random stream with back-pressure (R5, R6, R8)
    do_reset();
    for (int i = 0; i < 4000; i++)
      drive(($urandom % 10) < 7, 10'($urandom), ($urandom % 10) < 6);
    drain_and_count("random");

    // Clustered random around the wrap point
    do_reset();
    for (int i = 0; i < 2000; i++)
      drive(($urandom % 10) < 8, {2'($urandom), 8'(8'd250 + 8'($urandom % 12))},
            ($urandom % 10) < 8);
    drain_and_count("cluster");
  endtask

  initial begin
    fork
      body();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule